// File: doc/BRIEF.md
# Transmit Queue Block-Count Ready Gate

This block counts the fixed-size blocks currently held in a transmit queue. From that count it decides whether the transmitter may begin sending. A control/status word selects the ready policy. In the permissive policy, the ready flag rises as soon as one block is present. In the gated policy, the flag stays low until the block count is strictly above a programmable threshold. The gated policy lets the host fill the queue at its own pace without risking a starved transmitter. Its cost is that a small packet below the threshold waits in the queue until more blocks arrive.

The queue writer pulses an enqueue strobe for every block it adds. The transmitter pulses a dequeue strobe for every block it consumes, and it holds a busy input high while a packet is in flight. If the transmitter tries to take a block from an empty queue during a packet, the block raises a sticky underrun flag. Downstream abort logic uses this flag. Software clears the flag by writing the control word with its clear bit set.

Top module: `txq_ready_gate`

## Requirements
- R1: After reset the block count is 0, the policy field is 00b, the threshold is 0, the ready flag is low, the underrun flag is low, and the read word is all zeros.
- R2: An enqueue strobe alone raises the count by one, and a dequeue strobe alone lowers it by one. The new count appears on the ports right after the clock edge that samples the strobe.
- R3: When enqueue and dequeue are both asserted in one cycle and the count is non-zero, the count does not change. This includes a full queue.
- R4: A dequeue at count 0 leaves the count at 0. An enqueue alone at the capacity (DEPTH, default 32) leaves the count at DEPTH.
- R5: With policy 00b, the ready flag is high exactly when the count is at least 1. It follows the registered count with no extra delay.
- R6: With policy 01b, the ready flag is high only when the count is strictly greater than the threshold. At a count equal to the threshold it is low.
- R7: Policy codes 10b and 11b behave exactly like 00b.
- R8: A register write loads the policy from bits 25:24 and the threshold from bits THR_W-1:0 (default 5:0). The read word shows underrun at bit 31, ready at bit 30, the policy at bits 25:24, the count at bits 16 and up, and the threshold at bits 0 and up. All other bits read as 0.
- R9: The underrun flag is set at the edge that samples a dequeue while busy is high and the count is 0. A dequeue at count 0 with busy low does not set it.
- R10: The underrun flag stays set until a register write with bit 31 = 1. A write with bit 31 = 0 leaves it set. If a new underrun and a clearing write fall in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| blk_enq_i | input | 1 | One block added to the queue |
| blk_deq_i | input | 1 | Transmitter consumes one block |
| tx_busy_i | input | 1 | Transmitter is in the middle of a packet |
| cfg_wr_i | input | 1 | Write strobe for the control word |
| cfg_wdata_i | input | 32 | Control word write data |
| cfg_rdata_o | output | 32 | Control/status read word |
| blk_count_o | output | CNT_W | Current block count |
| q_ready_o | output | 1 | Queue may start transmitting |
| tx_underrun_o | output | 1 | Sticky underrun flag |

## Verification
The hardest situation to reach from the ports is the edge of capacity. Both the saturating enqueue and the simultaneous enqueue/dequeue at a full queue can only be exercised after DEPTH single enqueues. The stimulus therefore fills the queue to the brim in a dedicated scenario before applying those strobes. A second awkward case is an underrun that coincides with a clearing write. The bench drives a dequeue at an empty queue with busy high and a bit-31 write in the same cycle, then confirms that the set takes priority. The threshold boundary is approached one block at a time, so that the flag is observed both at count equal to the threshold and at one above it.

// File: rtl/txq_pkg.sv
package txq_pkg;
  typedef enum logic [1:0] {
    POL_ANY  = 2'b00,
    POL_GATE = 2'b01,
    POL_RSV2 = 2'b10,
    POL_RSV3 = 2'b11
  } qpolicy_e;

  localparam int POL_LSB  = 24;
  localparam int CLR_BIT  = 31;
  localparam int RDY_BIT  = 30;
  localparam int CNT_LSB  = 16;

  // Next occupancy: dequeue only takes an existing block, enqueue only fills free room
  function automatic int unsigned occ_next(input int unsigned cur, input logic enq,
                                           input logic deq, input int unsigned cap);
    int unsigned n;
    logic take;
    take = deq && (cur != 0);
    n = cur;
    if (take) n = n - 1;
    if (enq && (n < cap)) n = n + 1;
    return n;
  endfunction

  // Ready policy: gated compares strictly above threshold, every other code needs one block
  function automatic logic ready_eval(input qpolicy_e pol, input int unsigned cnt,
                                      input int unsigned thr);
    if (pol == POL_GATE) return cnt > thr;
    return cnt != 0;
  endfunction
endpackage

// File: rtl/txq_occ_counter.sv
module txq_occ_counter #(
  parameter int DEPTH = 32,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enq_i,
  input  logic             deq_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             empty_o
);
  import txq_pkg::*;

  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb cnt_d = CNT_W'(occ_next(32'(cnt_q), enq_i, deq_i, 32'(DEPTH)));

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o   = cnt_q;
  assign empty_o = (cnt_q == '0);

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL_CNT); // R4
  AST_CNT_PAIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (enq_i && deq_i && cnt_q != '0) |=> cnt_q == $past(cnt_q)); // R3
  AST_CNT_EMPTY_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    (deq_i && !enq_i && cnt_q == '0) |=> cnt_q == '0); // R4
  AST_CNT_FULL_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
    (enq_i && !deq_i && cnt_q == FULL_CNT) |=> cnt_q == FULL_CNT); // R4
endmodule

// File: rtl/txq_ctrl_reg.sv
module txq_ctrl_reg #(
  parameter int THR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [31:0]       wdata_i,
  output txq_pkg::qpolicy_e pol_o,
  output logic [THR_W-1:0]  thr_o,
  output logic              clr_o
);
  import txq_pkg::*;

  qpolicy_e         pol_q;
  logic [THR_W-1:0] thr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pol_q <= POL_ANY;
      thr_q <= '0;
    end else if (wr_i) begin
      pol_q <= qpolicy_e'(wdata_i[POL_LSB +: 2]);
      thr_q <= wdata_i[THR_W-1:0];
    end
  end

  assign pol_o = pol_q;
  assign thr_o = thr_q;
  assign clr_o = wr_i && wdata_i[CLR_BIT];

  AST_REG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> (pol_q == qpolicy_e'($past(wdata_i[POL_LSB +: 2])))); // R8
  AST_REG_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> $stable(thr_q)); // R8
endmodule

// File: rtl/txq_underrun_det.sv
module txq_underrun_det (
  input  logic clk,
  input  logic rst_n,
  input  logic deq_i,
  input  logic busy_i,
  input  logic empty_i,
  input  logic clr_i,
  output logic ur_o
);
  logic starve;
  logic ur_q;

  assign starve = deq_i && busy_i && empty_i;

  always_ff @(posedge clk) begin
    if (!rst_n)      ur_q <= 1'b0;
    else if (starve) ur_q <= 1'b1;
    else if (clr_i)  ur_q <= 1'b0;
  end

  assign ur_o = ur_q;

  AST_UR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    starve |=> ur_q); // R9
  AST_UR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ur_q && !clr_i) |=> ur_q); // R10
  AST_UR_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    (!ur_q && !starve) |=> !ur_q); // R9
endmodule

// File: rtl/txq_ready_gate.sv
module txq_ready_gate #(
  parameter int DEPTH = 32,
  parameter int THR_W = 6,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             blk_enq_i,
  input  logic             blk_deq_i,
  input  logic             tx_busy_i,
  input  logic             cfg_wr_i,
  input  logic [31:0]      cfg_wdata_i,
  output logic [31:0]      cfg_rdata_o,
  output logic [CNT_W-1:0] blk_count_o,
  output logic             q_ready_o,
  output logic             tx_underrun_o
);
  import txq_pkg::*;

  logic [CNT_W-1:0] cnt;
  logic             empty;
  qpolicy_e         pol;
  logic [THR_W-1:0] thr;
  logic             ur_clr;
  logic             ur;
  logic             ready;

  txq_occ_counter #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .enq_i(blk_enq_i), .deq_i(blk_deq_i),
    .cnt_o(cnt), .empty_o(empty)
  );

  txq_ctrl_reg #(.THR_W(THR_W)) u_reg (
    .clk(clk), .rst_n(rst_n), .wr_i(cfg_wr_i), .wdata_i(cfg_wdata_i),
    .pol_o(pol), .thr_o(thr), .clr_o(ur_clr)
  );

  txq_underrun_det u_ur (
    .clk(clk), .rst_n(rst_n), .deq_i(blk_deq_i), .busy_i(tx_busy_i),
    .empty_i(empty), .clr_i(ur_clr), .ur_o(ur)
  );

  always_comb ready = ready_eval(pol, 32'(cnt), 32'(thr));

  always_comb begin
    cfg_rdata_o = '0;
    cfg_rdata_o[CLR_BIT]          = ur;
    cfg_rdata_o[RDY_BIT]          = ready;
    cfg_rdata_o[POL_LSB +: 2]     = pol;
    cfg_rdata_o[CNT_LSB +: CNT_W] = cnt;
    cfg_rdata_o[0 +: THR_W]       = thr;
  end

  assign blk_count_o   = cnt;
  assign q_ready_o     = ready;
  assign tx_underrun_o = ur;

  AST_RDY_EMPTY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> !ready); // R5
  AST_RDY_GATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pol == POL_GATE && 32'(cnt) <= 32'(thr)) |-> !ready); // R6
  AST_RDY_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (pol != POL_GATE && !empty) |-> ready); // R7
endmodule

// File: tb/txq_ready_gate_tb_top.sv
module txq_ready_gate_tb_top;
  localparam int DEPTH = 32;
  localparam int THR_W = 6;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             enq = 1'b0, deq = 1'b0, busy = 1'b0, wr = 1'b0;
  logic [31:0]      wdata = '0;
  logic [31:0]      rdata;
  logic [CNT_W-1:0] cnt;
  logic             rdy, ur;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  txq_ready_gate #(.DEPTH(DEPTH), .THR_W(THR_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .blk_enq_i(enq), .blk_deq_i(deq), .tx_busy_i(busy),
    .cfg_wr_i(wr), .cfg_wdata_i(wdata), .cfg_rdata_o(rdata), .blk_count_o(cnt),
    .q_ready_o(rdy), .tx_underrun_o(ur)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One clock with the given strobes, then sample 1 ns after the edge
  task automatic cyc(input logic e, input logic d, input logic b);
    enq = e; deq = d; busy = b;
    @(posedge clk); #1;
    enq = 0; deq = 0; busy = 0;
  endtask

  task automatic wr_cfg(input logic clr, input logic [1:0] pol, input int thr);
    wr = 1; wdata = '0; wdata[31] = clr; wdata[25:24] = pol; wdata[THR_W-1:0] = THR_W'(thr);
    @(posedge clk); #1;
    wr = 0; wdata = '0;
  endtask

  task automatic t_reset();
    chk("R1 count", 32'(cnt), 0);
    chk("R1 ready", 32'(rdy), 0);
    chk("R1 underrun", 32'(ur), 0);
    chk("R1 rdata", rdata, 0);
  endtask

  task automatic t_count();
    cyc(1, 0, 0); chk("R2 count after one enq", 32'(cnt), 1);
    chk("R5 ready at one block", 32'(rdy), 1);
    cyc(1, 0, 0); cyc(1, 0, 0); chk("R2 count after three enq", 32'(cnt), 3);
    cyc(0, 1, 1); chk("R2 count after deq", 32'(cnt), 2);
    cyc(1, 1, 1); chk("R3 pair no change", 32'(cnt), 2);
    cyc(0, 1, 0); cyc(0, 1, 0); chk("R2 drained", 32'(cnt), 0);
    chk("R5 ready low when empty", 32'(rdy), 0);
    cyc(0, 1, 0); chk("R4 deq at empty", 32'(cnt), 0);
    chk("R9 no underrun when idle", 32'(ur), 0);
  endtask

  task automatic t_underrun();
    cyc(0, 1, 1); chk("R9 underrun set", 32'(ur), 1);
    chk("R4 count stays 0", 32'(cnt), 0);
    wr_cfg(0, 2'b00, 0); chk("R10 write without clear", 32'(ur), 1);
    cyc(0, 0, 0); chk("R10 sticky", 32'(ur), 1);
    wr_cfg(1, 2'b00, 0); chk("R10 cleared", 32'(ur), 0);
    // set and clear in the same cycle: set wins
    wr = 1; wdata = 32'h8000_0000; enq = 0; deq = 1; busy = 1;
    @(posedge clk); #1;
    wr = 0; wdata = '0; deq = 0; busy = 0;
    chk("R10 set beats clear", 32'(ur), 1);
    wr_cfg(1, 2'b00, 0); chk("R10 cleared again", 32'(ur), 0);
  endtask

  task automatic t_gate();
    wr_cfg(0, 2'b01, 3);
    for (int i = 1; i <= 3; i++) begin
      cyc(1, 0, 0);
      chk("R6 ready low at or below threshold", 32'(rdy), 0);
    end
    cyc(1, 0, 0); chk("R6 ready above threshold", 32'(rdy), 1);
    cyc(0, 1, 1); chk("R6 back to threshold", 32'(rdy), 0);
    chk("R8 readback", rdata, {1'b0, 1'b0, 4'b0, 2'b01, 8'd3, 10'd0, 6'd3});
  endtask

  task automatic t_modes();
    wr_cfg(0, 2'b10, 3); chk("R7 code 10 ready", 32'(rdy), 1);
    wr_cfg(0, 2'b11, 7); chk("R7 code 11 ready", 32'(rdy), 1);
    chk("R8 readback code 11", rdata, {1'b0, 1'b1, 4'b0, 2'b11, 8'd3, 10'd0, 6'd7});
    cyc(0, 1, 0); cyc(0, 1, 0); cyc(0, 1, 0);
    chk("R7 code 11 empty", 32'(rdy), 0);
    wr_cfg(0, 2'b00, 0);
  endtask

  task automatic t_full();
    for (int i = 0; i < DEPTH; i++) cyc(1, 0, 0);
    chk("R2 filled", 32'(cnt), DEPTH);
    cyc(1, 0, 0); chk("R4 enq at full", 32'(cnt), DEPTH);
    cyc(1, 1, 1); chk("R3 pair at full", 32'(cnt), DEPTH);
    cyc(0, 1, 1); chk("R2 one out of full", 32'(cnt), DEPTH - 1);
  endtask

  initial begin
    #1000000;
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_count();
    t_underrun();
    t_gate();
    t_modes();
    t_full();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule